// File: doc/BRIEF.md
# Polyphase Interpolating Pulse-Shaping Filter

This block shapes the pulses of one real data path of a modulator. Each input symbol arrives on a valid/ready handshake. For every accepted symbol the block emits IP interpolated output samples, one per polyphase phase, so the output rate is IP times the input rate. Each output is a convolution of the DS most recent input symbols with one phase's set of coefficients. A single multiplier-accumulator is shared in time: it handles one tap per clock and walks through the phases one after another.

A single write port loads a small control word and a coefficient RAM. The RAM holds two coefficient banks, and the control word picks which bank is active. The interpolation factor, the span and the active bank can all change while the block is running. A control change takes hold only when the next input symbol is accepted, so no output ever mixes two settings. To swap coefficients safely, software writes the inactive bank and then flips the bank-select bit.

Top module: `pulse_shaper_fir`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0. The delay line holds zeros, so the first symbol's outputs contain only the newest-tap products.
- R2: The interpolation factor comes from control bits [1:0]: 0 selects 4, 1 selects 8, and 2 or 3 select 16. Each accepted symbol yields exactly IP outputs. Their out_phase values run 0, 1, …, IP-1 in order.
- R3: The span comes from control bits [7:4], which hold DS-1. A field value below 3 is treated as 3, so DS is always 4 to 16.
- R4: The output for phase p is Σ_{t=0..DS-1} C[base + p + t·IP] · D[n-t], where D[n] is the newest symbol. With IP=4 and DS=4, phase 1 is C1·D[n] + C5·D[n-1] + C9·D[n-2] + C13·D[n-3].
- R5: The full-precision sum is rounded by adding 2^14 and then arithmetic-shifting right by 15. The result is saturated to the signed 16-bit range [-32768, 32767].
- R6: Control bit 8 selects the coefficient bank. The bank base address is 0 for bank 0 and 256 for bank 1. The coefficient at RAM address A is written with wr_coef=1, wr_addr=A and wr_data=value.
- R7: After an accept, in_ready stays low for exactly IP·DS clocks. Successive outputs are DS clocks apart. The last output appears in the cycle in_ready returns high.
- R8: A control write made while a symbol is being processed does not change that symbol's outputs. It takes effect at the next accepted symbol.
- R9: in_valid asserted while in_ready is low is ignored. The delay line shifts only on an accepted symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Block can accept a symbol |
| in_data | input | 16 | Signed input symbol |
| wr_en | input | 1 | Register write strobe |
| wr_coef | input | 1 | 1: coefficient RAM write, 0: control write |
| wr_addr | input | 9 | Coefficient RAM address |
| wr_data | input | 16 | Write data (coefficient, or control word) |
| out_valid | output | 1 | Output sample valid (one-cycle pulse) |
| out_data | output | 16 | Rounded, saturated output sample |
| out_phase | output | 4 | Phase index of the output sample |

## Verification
The bench runs every interpolation factor and several spans, including a span field small enough to be clamped and the largest 16×16 case in bank 1. An indexing or clamp error shows up as wrong output values or a wrong number of outputs. It changes the control word and writes into the inactive bank in the middle of a symbol period. A design that applied those writes immediately would corrupt the outputs still in flight. It also holds in_valid high while the block is busy. A design that shifted its delay line on that request would give wrong values for the next symbol. Full-scale inputs drive both saturation limits, and a half-LSB case checks the round-half-up step; a truncating or wrapping design would be off there.

// File: rtl/pulse_shaper_fir.sv
module pulse_shaper_fir #(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int MAX_SPAN = 16,
  parameter int MAX_IP   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          wr_en,
  input  logic          wr_coef,
  input  logic [$clog2(2*MAX_IP*MAX_SPAN)-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [$clog2(MAX_IP)-1:0] out_phase
);
  localparam int TW   = $clog2(MAX_SPAN);
  localparam int PW   = $clog2(MAX_IP);
  localparam int BW   = $clog2(MAX_IP*MAX_SPAN);
  localparam int PRW  = DW + CW;
  localparam int ACCW = PRW + TW;
  localparam logic signed [ACCW-1:0] OMAX = ACCW'(2**(DW-1) - 1);
  localparam logic signed [ACCW-1:0] OMIN = -OMAX - ACCW'(1);

  logic signed [CW-1:0] ram [2*MAX_IP*MAX_SPAN];
  logic signed [DW-1:0] dl [MAX_SPAN];

  logic [1:0]    c_ip, ip_sel;
  logic [TW-1:0] c_span, span_m1;
  logic          c_bank, bank;
  logic          busy;
  logic [PW-1:0] phase;
  logic [TW-1:0] tap;
  logic [BW-1:0] idx;
  logic signed [ACCW-1:0] acc, acc_nx, rnd, shr;
  logic signed [PRW-1:0]  prod;
  logic [PW:0]   ip_n;
  logic [PW-1:0] last_phase;
  logic [DW-1:0] sat;
  logic          accept;

  assign in_ready   = ~busy;
  assign accept     = in_valid & ~busy;
  assign ip_n       = (ip_sel == 2'd0) ? (PW+1)'(4) :
                      (ip_sel == 2'd1) ? (PW+1)'(8) : (PW+1)'(16);
  assign last_phase = PW'(ip_n - 1'b1);
  assign prod       = ram[{bank, idx}] * dl[tap];
  assign acc_nx     = acc + ACCW'(prod);
  assign rnd        = acc_nx + (ACCW'(1) <<< (CW-2));
  assign shr        = rnd >>> (CW-1);
  assign sat        = (shr > OMAX) ? DW'(OMAX) :
                      (shr < OMIN) ? DW'(OMIN) : shr[DW-1:0];

  always_ff @(posedge clk)
    if (wr_en && wr_coef) ram[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_ip   <= 2'd0;
      c_span <= TW'(3);
      c_bank <= 1'b0;
    end else if (wr_en && !wr_coef) begin
      c_ip   <= wr_data[1:0];
      c_span <= wr_data[4 +: TW];
      c_bank <= wr_data[8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_SPAN; i++) dl[i] <= '0;
      ip_sel    <= 2'd0;
      span_m1   <= TW'(3);
      bank      <= 1'b0;
      busy      <= 1'b0;
      phase     <= '0;
      tap       <= '0;
      idx       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_phase <= '0;
    end else if (accept) begin
      for (int i = MAX_SPAN-1; i > 0; i--) dl[i] <= dl[i-1];
      dl[0]     <= in_data;
      ip_sel    <= c_ip;
      span_m1   <= (c_span < TW'(3)) ? TW'(3) : c_span;
      bank      <= c_bank;
      busy      <= 1'b1;
      phase     <= '0;
      tap       <= '0;
      idx       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
    end else if (busy) begin
      if (tap == span_m1) begin
        out_data  <= sat;
        out_phase <= phase;
        out_valid <= 1'b1;
        acc       <= '0;
        tap       <= '0;
        phase     <= phase + 1'b1;
        idx       <= BW'(phase) + BW'(1);
        if (phase == last_phase) busy <= 1'b0;
      end else begin
        out_valid <= 1'b0;
        acc       <= acc_nx;
        tap       <= tap + 1'b1;
        idx       <= idx + BW'(ip_n);
      end
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

module pulse_shaper_fir_chk #(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [PW-1:0] out_phase,
  input logic [PW-1:0] last_phase
);
  logic [PW-1:0] exp_phase;

  always_ff @(posedge clk) begin
    if (!rst_n)                   exp_phase <= '0;
    else if (in_valid && in_ready) exp_phase <= '0;
    else if (out_valid)           exp_phase <= exp_phase + 1'b1;
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R7
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_phase == exp_phase)); // R2
  AST_LAST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (out_valid && out_phase == last_phase)); // R2
  AST_OUTPUT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && $past(in_ready)) |-> !out_valid); // R7
endmodule

bind pulse_shaper_fir pulse_shaper_fir_chk #(.PW($clog2(MAX_IP))) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_phase(out_phase), .last_phase(last_phase)
);

// File: tb/pulse_shaper_fir_tb_top.sv
module pulse_shaper_fir_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        wr_en = 1'b0;
  logic        wr_coef = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic [3:0]  out_phase;

  always #2.5 clk = ~clk;

  pulse_shaper_fir dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wr_en(wr_en), .wr_coef(wr_coef), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_valid(out_valid), .out_data(out_data),
    .out_phase(out_phase)
  );

  typedef struct {
    int    phase;
    int    value;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int n_chk = 0;
  int n_fail = 0;
  int coef_m [512];
  int dl_m [16];
  int p_ip = 0, p_span = 3, p_bank = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wr_c(input int addr, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_coef = 1'b1; wr_addr = 9'(addr); wr_data = 16'(val);
    coef_m[addr] = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_ctrl(input int ipc, input int spanf, input int bnk);
    @(negedge clk);
    wr_en = 1'b1; wr_coef = 1'b0; wr_addr = '0;
    wr_data = 16'((bnk << 8) | (spanf << 4) | ipc);
    p_ip = ipc; p_span = spanf; p_bank = bnk;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input int d, input string tag);
    int ip, ds, base;
    longint acc, r;
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    ip   = (p_ip == 0) ? 4 : (p_ip == 1) ? 8 : 16;
    ds   = (p_span < 3) ? 4 : p_span + 1;
    base = p_bank * 256;
    for (int i = 15; i > 0; i--) dl_m[i] = dl_m[i-1];
    dl_m[0] = d;
    for (int p = 0; p < ip; p++) begin
      acc = 0;
      for (int t = 0; t < ds; t++)
        acc += longint'(coef_m[base + p + t*ip]) * longint'(dl_m[t]);
      r = (acc + 16384) >>> 15;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      e.phase = p; e.value = int'(r); e.tag = tag;
      sbq.push_back(e);
    end
    in_valid = 1'b1; in_data = 16'(d);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle(output int cnt);
    cnt = 0;
    while (!in_ready) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && out_valid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R2", "unexpected output phase", int'(out_phase), -1);
      end else begin
        e = sbq.pop_front();
        check(int'(out_phase) == e.phase, "R2", "output phase",
              int'(out_phase), e.phase);
        check(int'($signed(out_data)) == e.value, e.tag, "output value",
              int'($signed(out_data)), e.value);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    bit held_low;
    for (int i = 0; i < 16; i++) dl_m[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    for (int a = 0; a < 512; a++) wr_c(a, ((a * 1237 + 91) % 16001) - 8000);

    // R1: delay line starts at zero; default IP=4, DS=4
    send(20000, "R1");
    wait_idle(cnt);
    check(cnt == 16, "R7", "busy cycles IP4 DS4", cnt, 16);

    // R4: IP=4 DS=4 polyphase sums
    send(-15000, "R4"); send(7000, "R4"); send(31000, "R4");
    send(-32768, "R4"); send(123, "R4");

    // R3/R2: IP=8, DS=6
    wr_ctrl(1, 5, 0);
    send(9000, "R3");
    wait_idle(cnt);
    check(cnt == 48, "R7", "busy cycles IP8 DS6", cnt, 48);
    send(-4000, "R3"); send(25000, "R3"); send(-19000, "R3");

    // R6: IP=16, DS=16, bank 1
    wr_ctrl(2, 15, 1);
    send(11111, "R6");
    wait_idle(cnt);
    check(cnt == 256, "R7", "busy cycles IP16 DS16", cnt, 256);
    send(-22222, "R6"); send(3333, "R6");

    // R3: span field 1 clamps to DS=4; code 3 means IP=16
    wr_ctrl(0, 1, 0);
    send(5000, "R3");
    wait_idle(cnt);
    check(cnt == 16, "R3", "busy cycles clamped span", cnt, 16);
    send(-6000, "R3");
    wr_ctrl(3, 3, 0);
    send(1500, "R2");
    wait_idle(cnt);
    check(cnt == 64, "R2", "busy cycles IP code 3", cnt, 64);

    // R8: mid-period control change and inactive-bank write
    wr_ctrl(0, 3, 0);
    send(14000, "R8");
    wr_ctrl(1, 3, 1);
    wr_c(300, 7777);
    wait_idle(cnt);
    send(-9000, "R8");
    wait_idle(cnt);
    check(cnt == 32, "R8", "busy cycles after deferred control", cnt, 32);

    // R9: request while busy is ignored
    send(4242, "R9");
    held_low = 1'b1;
    in_valid = 1'b1; in_data = 16'(12345);
    repeat (5) begin
      @(negedge clk);
      if (in_ready) held_low = 1'b0;
    end
    in_valid = 1'b0;
    check(held_low, "R9", "in_ready low during ignored request", int'(held_low), 1);
    wait_idle(cnt);
    send(-1000, "R9"); send(2000, "R9");

    // R5: saturation at both limits and round-half-up
    wr_ctrl(0, 3, 0);
    wait_idle(cnt);
    for (int a = 0; a < 16; a++) wr_c(a, 32767);
    repeat (4) send(32767, "R5");
    repeat (4) send(-32768, "R5");
    wait_idle(cnt);
    for (int a = 0; a < 16; a++) wr_c(a, (a == 0) ? 16384 : 0);
    send(1, "R5"); send(-1, "R5"); send(3, "R5"); send(-3, "R5");
    wait_idle(cnt);
    repeat (10) @(negedge clk);
    check(sbq.size() == 0, "R2", "leftover expected outputs", sbq.size(), 0);
    check(in_ready == 1'b1, "R7", "idle at end", int'(in_ready), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule